// File: doc/BRIEF.md
# Register-Offset Halfword Load Unit

This unit carries out a single halfword load whose address is a base register plus an index register. It accepts a 32-bit instruction word and checks it against the expected encoding. It then reads two operands through a register-file read port. When the base field is 31, the base is the stack pointer rather than a general register. The index is widened by zero- or sign-extension, or taken whole, and may be doubled. The sum of base and index forms a 64-bit address.

A 2-byte read is then issued on a valid/ready request channel. The returned halfword is zero-extended to the full 64-bit register width and sent out on a write-back port. Encodings it cannot run raise an undefined flag. A misaligned stack-pointer base raises an alignment flag. In both cases no memory request is made and nothing is written back.

The unit handles one instruction at a time. It is intended to sit behind an issue stage that holds the instruction until it is accepted.

Top module: `hword_ld_unit`

## Requirements
- R1: The word is recognised only when bits 31..21 are 01111000011 and bits 11..10 are 10. The fields are: index register at 20..16, extend option at 15..13, scale bit at 12, base register at 9..5, destination at 4..0. Any other word raises `undef_flag`.
- R2: When option bit 1 is 0, `undef_flag` is high for exactly one cycle, in the second cycle after the instruction is taken. No memory request and no write-back occur.
- R3: The extend option selects the index form: 010 zero-extends the low 32 index bits, 110 sign-extends them, and 011 or 111 use all 64 bits.
- R4: The scale bit shifts the extended index left by one when 1 and leaves it unshifted when 0. The shift is applied after extension.
- R5: The request address is (base + shifted index) mod 2^64. `rf_base_sel` carries the base field and `rf_index_sel` carries the index field. A base field of 31 takes `sp_value` instead of `rf_base_data`.
- R6: With a base field of 31 and any of `sp_value[3:0]` nonzero, `align_fault` pulses for one cycle in the second cycle after accept, with no request and no write-back. A misaligned `sp_value` has no effect when the base field is not 31.
- R7: `mem_req_valid` rises in the second cycle after accept. It stays high with a stable address until the cycle in which `mem_req_ready` is seen. `mem_req_bytes` reads 2.
- R8: `wb_valid` is high for exactly one cycle, the cycle after `mem_rsp_valid` is seen. `wb_sel` is the destination field, and `wb_data` carries the response halfword in bits 15..0 with zeros above.
- R9: `instr_ready` is high only while idle. An `instr_valid` presented while busy is dropped and starts nothing.
- R10: After reset the unit is idle: `instr_ready` is high and `mem_req_valid`, `wb_valid`, `undef_flag` and `align_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_word | input | 32 | Instruction word |
| instr_ready | output | 1 | Unit idle, instruction taken when valid |
| rf_base_sel | output | 5 | Register-file read select for the base |
| rf_base_data | input | 64 | Base register value |
| rf_index_sel | output | 5 | Register-file read select for the index |
| rf_index_data | input | 64 | Index register value |
| sp_value | input | 64 | Current stack pointer |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_bytes | output | 4 | Request size in bytes (2) |
| mem_req_ready | input | 1 | Request accepted |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 16 | Returned halfword |
| wb_valid | output | 1 | Write-back strobe |
| wb_sel | output | 5 | Destination register |
| wb_data | output | 64 | Zero-extended result |
| undef_flag | output | 1 | Undefined-encoding pulse |
| align_fault | output | 1 | Stack-pointer alignment fault pulse |

## Verification
An instruction taken at edge E0 is decoded after E0. Its outcome becomes visible after E1: either the request with its address, or one of the two flags. With ready and response held high, the write-back strobe appears after E3 and the unit is idle again after E4. Each vector is driven at a falling edge, and each result is sampled at the falling edge that follows exactly the edge where it is due, so a result one cycle early or late is reported. Stall cases hold back ready or the response for several cycles and check every intermediate cycle for a held address and an absent strobe.

// File: rtl/hld_pkg.sv
// Shared types and encoding constants for the halfword load unit.
package hld_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_REQ,
        ST_RSP,
        ST_WB
    } hld_state_e;

    typedef struct packed {
        logic       match;
        logic [2:0] opt;
        logic       scale;
        logic [4:0] rm;
        logic [4:0] rn;
        logic [4:0] rt;
    } hld_fields_t;

    localparam logic [10:0] HLD_OPC_HI = 11'b01111000011;
    localparam logic [1:0]  HLD_OPC_LO = 2'b10;
    localparam logic [4:0]  HLD_SP_SEL = 5'd31;
endpackage

// File: rtl/hld_decode.sv
// Field extraction and legality check for the load encoding.
// Assumes: a 32-bit word held stable while decoded; purely combinational.
module hld_decode
    import hld_pkg::*;
(
    input  logic [31:0] word,
    output hld_fields_t fields,
    output logic        reject
);
    // Split the word into its fields and test the fixed opcode bits.
    always_comb begin
        fields.match = (word[31:21] == HLD_OPC_HI) && (word[11:10] == HLD_OPC_LO);
        fields.rm    = word[20:16];
        fields.opt   = word[15:13];
        fields.scale = word[12];
        fields.rn    = word[9:5];
        fields.rt    = word[4:0];
        reject       = !fields.match || !fields.opt[1];
    end
endmodule

// File: rtl/hld_agen.sv
// Address generator: extends and scales the index, picks the base and adds.
// Assumes: option bit 1 already checked by the decoder; combinational.
module hld_agen
    import hld_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int ALIGN_LOG2  = 4
) (
    input  logic [XLEN-1:0] base_gpr,
    input  logic [XLEN-1:0] sp,
    input  logic [XLEN-1:0] index,
    input  logic [2:0]      opt,
    input  logic            scale,
    input  logic [4:0]      rn,
    output logic [XLEN-1:0] addr,
    output logic            sp_misaligned
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] ext_index;
    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] base;
    logic            use_sp;

    // Widen the index: whole register, or low half zero/sign extended.
    always_comb begin
        if (opt[0]) begin
            ext_index = index;
        end else if (opt[2]) begin
            ext_index = {{HALF{index[HALF-1]}}, index[HALF-1:0]};
        end else begin
            ext_index = {{HALF{1'b0}}, index[HALF-1:0]};
        end
    end

    // Scale after extension, select base, form the sum.
    always_comb begin
        scaled = scale ? {ext_index[XLEN-2:0], 1'b0} : ext_index;
        use_sp = (rn == HLD_SP_SEL);
        base   = use_sp ? sp : base_gpr;
        addr   = base + scaled;
    end

    // Alignment test on the stack pointer when it is the base.
    generate
        if (ALIGN_LOG2 > 0) begin : g_align
            assign sp_misaligned = use_sp && (|sp[ALIGN_LOG2-1:0]);
        end else begin : g_noalign
            assign sp_misaligned = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/hld_ctrl.sv
// Sequencer: accept, decide, request, wait for data, write back.
// Assumes: decode/agen results are valid during the cycle after accept,
// while the register-file and stack-pointer inputs are held.
module hld_ctrl
    import hld_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              instr_ready,
    output logic [31:0]       instr_q,
    input  logic              reject,
    input  logic              misaligned,
    input  logic [XLEN-1:0]   addr_in,
    output logic              mem_req_valid,
    output logic [XLEN-1:0]   mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              wb_valid,
    output logic [XLEN-1:0]   wb_data,
    output logic              undef_flag,
    output logic              align_fault
);
    hld_state_e        state_q;
    logic [XLEN-1:0]   addr_q;
    logic [DATA_W-1:0] data_q;
    logic              undef_q;
    logic              align_q;

    // State, captured instruction, address, data and one-cycle flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            instr_q <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            undef_q <= 1'b0;
            align_q <= 1'b0;
        end else begin
            undef_q <= 1'b0;
            align_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (instr_valid) begin
                        instr_q <= instr_word;
                        state_q <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (reject) begin
                        undef_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (misaligned) begin
                        align_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        addr_q  <= addr_in;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state_q <= ST_RSP;
                end
                ST_RSP: begin
                    if (mem_rsp_valid) begin
                        data_q  <= mem_rsp_data;
                        state_q <= ST_WB;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from state.
    always_comb begin
        instr_ready   = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_REQ);
        mem_req_addr  = addr_q;
        wb_valid      = (state_q == ST_WB);
        wb_data       = {{(XLEN-DATA_W){1'b0}}, data_q};
        undef_flag    = undef_q;
        align_fault   = align_q;
    end
endmodule

// File: rtl/hword_ld_unit.sv
// Top of the register-offset halfword load unit.
// Assumes: register-file reads return combinationally for the selects
// driven, and sp_value is stable while an instruction is decoded.
module hword_ld_unit
    import hld_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int DATA_W     = 16,
    parameter int ALIGN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              instr_ready,
    output logic [4:0]        rf_base_sel,
    input  logic [XLEN-1:0]   rf_base_data,
    output logic [4:0]        rf_index_sel,
    input  logic [XLEN-1:0]   rf_index_data,
    input  logic [XLEN-1:0]   sp_value,
    output logic              mem_req_valid,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [3:0]        mem_req_bytes,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              wb_valid,
    output logic [4:0]        wb_sel,
    output logic [XLEN-1:0]   wb_data,
    output logic              undef_flag,
    output logic              align_fault
);
    localparam logic [3:0] ACCESS_BYTES = 4'(DATA_W / 8);

    logic [31:0]     instr_q;
    hld_fields_t     fields;
    logic            reject;
    logic [XLEN-1:0] addr;
    logic            misaligned;

    hld_decode u_decode (
        .word   (instr_q),
        .fields (fields),
        .reject (reject)
    );

    hld_agen #(
        .XLEN       (XLEN),
        .ALIGN_LOG2 (ALIGN_LOG2)
    ) u_agen (
        .base_gpr      (rf_base_data),
        .sp            (sp_value),
        .index         (rf_index_data),
        .opt           (fields.opt),
        .scale         (fields.scale),
        .rn            (fields.rn),
        .addr          (addr),
        .sp_misaligned (misaligned)
    );

    hld_ctrl #(
        .XLEN   (XLEN),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid   (instr_valid),
        .instr_word    (instr_word),
        .instr_ready   (instr_ready),
        .instr_q       (instr_q),
        .reject        (reject),
        .misaligned    (misaligned),
        .addr_in       (addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .wb_valid      (wb_valid),
        .wb_data       (wb_data),
        .undef_flag    (undef_flag),
        .align_fault   (align_fault)
    );

    // Register-file selects, destination and fixed access size.
    always_comb begin
        rf_base_sel   = fields.rn;
        rf_index_sel  = fields.rm;
        wb_sel        = fields.rt;
        mem_req_bytes = ACCESS_BYTES;
    end
endmodule

// File: rtl/hld_checker.sv
// Port-level properties of the halfword load unit, bound to its top.
module hld_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_ready,
    input logic            mem_req_valid,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            mem_req_ready,
    input logic            wb_valid,
    input logic [XLEN-1:0] wb_data,
    input logic            undef_flag,
    input logic            align_fault
);
    // R7: an unaccepted request stays up with the same address.
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8: write-back strobe lasts one cycle.
    a_r8_wb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    // R8: upper result bits are zero.
    a_r8_wb_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_data[XLEN-1:16] == '0));

    // R2: a fault flag never coincides with an access or write-back.
    a_r2_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_flag || align_fault) |-> (!mem_req_valid && !wb_valid));

    // R6: the two fault flags are exclusive.
    a_r6_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(undef_flag && align_fault));

    // R9: no new instruction is taken during an access.
    a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || wb_valid) |-> !instr_ready);

    // R2/R6: a flag is followed by an idle cycle, not a request.
    a_r2_flag_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_flag || align_fault) |=> !mem_req_valid);
endmodule

bind hword_ld_unit hld_checker #(.XLEN(XLEN)) u_hld_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_ready   (instr_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .wb_valid      (wb_valid),
    .wb_data       (wb_data),
    .undef_flag    (undef_flag),
    .align_fault   (align_fault)
);

// File: tb/hword_ld_unit_bench.sv
module hword_ld_unit_bench;
    localparam int NV = 16;
    localparam logic [1:0] K_OK = 2'd0, K_UND = 2'd1, K_ALN = 2'd2;

    typedef struct packed {
        logic [2:0]  opt;
        logic        s;
        logic [4:0]  rm;
        logic [4:0]  rn;
        logic [4:0]  rt;
        logic [1:0]  lo;
        logic [63:0] sp;
        logic [1:0]  kind;
        logic [63:0] addr;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'b011, 1'b0, 5'd4, 5'd1,  5'd7,  2'b10, 64'h8000, K_OK,  64'h1010},
        '{3'b011, 1'b1, 5'd4, 5'd1,  5'd8,  2'b10, 64'h8000, K_OK,  64'h1020},
        '{3'b010, 1'b0, 5'd2, 5'd1,  5'd9,  2'b10, 64'h8000, K_OK,  64'h1_0000_0FFE},
        '{3'b110, 1'b0, 5'd2, 5'd1,  5'd10, 2'b10, 64'h8000, K_OK,  64'h0FFE},
        '{3'b110, 1'b1, 5'd2, 5'd1,  5'd11, 2'b10, 64'h8000, K_OK,  64'h0FFC},
        '{3'b111, 1'b0, 5'd3, 5'd1,  5'd12, 2'b10, 64'h8000, K_OK,  64'h0FF0},
        '{3'b010, 1'b1, 5'd5, 5'd1,  5'd13, 2'b10, 64'h8000, K_OK,  64'h1008},
        '{3'b011, 1'b0, 5'd5, 5'd1,  5'd14, 2'b10, 64'h8000, K_OK,  64'h1234_5678_0000_1004},
        '{3'b011, 1'b0, 5'd4, 5'd31, 5'd0,  2'b10, 64'h8000, K_OK,  64'h8010},
        '{3'b111, 1'b1, 5'd3, 5'd31, 5'd30, 2'b10, 64'h8000, K_OK,  64'h7FE0},
        '{3'b000, 1'b0, 5'd4, 5'd1,  5'd2,  2'b10, 64'h8000, K_UND, 64'h0},
        '{3'b101, 1'b1, 5'd4, 5'd1,  5'd3,  2'b10, 64'h8000, K_UND, 64'h0},
        '{3'b011, 1'b0, 5'd4, 5'd1,  5'd4,  2'b00, 64'h8000, K_UND, 64'h0},
        '{3'b011, 1'b0, 5'd4, 5'd31, 5'd5,  2'b10, 64'h8008, K_ALN, 64'h0},
        '{3'b011, 1'b0, 5'd4, 5'd31, 5'd6,  2'b10, 64'h8001, K_ALN, 64'h0},
        '{3'b011, 1'b0, 5'd4, 5'd1,  5'd6,  2'b10, 64'h8008, K_OK,  64'h1010}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        instr_ready;
    logic [4:0]  rf_base_sel, rf_index_sel, wb_sel;
    logic [63:0] rf_base_data, rf_index_data;
    logic [63:0] sp_value = 64'h8000;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic [3:0]  mem_req_bytes;
    logic        mem_req_ready = 1'b1;
    logic        mem_rsp_valid = 1'b1;
    logic [15:0] mem_rsp_data;
    logic        wb_valid;
    logic [63:0] wb_data;
    logic        undef_flag, align_fault;
    logic [63:0] gpr [32];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    // Register file and memory models.
    assign rf_base_data  = (rf_base_sel == 5'd31) ? 64'hBAD0_BAD0_BAD0_BAD0 : gpr[rf_base_sel];
    assign rf_index_data = gpr[rf_index_sel];
    assign mem_rsp_data  = mem_req_addr[15:0] ^ 16'hC3A5;

    hword_ld_unit u_hword_ld_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_ready(instr_ready), .rf_base_sel(rf_base_sel), .rf_base_data(rf_base_data),
        .rf_index_sel(rf_index_sel), .rf_index_data(rf_index_data), .sp_value(sp_value),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_bytes(mem_req_bytes),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_data(wb_data),
        .undef_flag(undef_flag), .align_fault(align_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input vec_t v);
        return {11'b01111000011, v.rm, v.opt, v.s, v.lo, v.rn, v.rt};
    endfunction

    // Drive one vector and check its outcome cycle by cycle.
    task automatic run_vec(input vec_t v);
        logic [63:0] exp_wb;
        exp_wb = {48'h0, v.addr[15:0] ^ 16'hC3A5};
        @(negedge clk);
        sp_value    = v.sp;
        instr_word  = enc(v);
        instr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        chk(!instr_ready, "R9 busy after accept", 64'(instr_ready), 64'h0);
        @(posedge clk);
        @(negedge clk);
        if (v.kind == K_OK) begin
            chk(mem_req_valid, "R7 request due", 64'(mem_req_valid), 64'h1);
            chk(mem_req_addr == v.addr, "R5 R3 R4 address", mem_req_addr, v.addr);
            chk(mem_req_bytes == 4'd2, "R7 size", 64'(mem_req_bytes), 64'h2);
            chk(!undef_flag && !align_fault, "R6 no flag", 64'({undef_flag, align_fault}), 64'h0);
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            chk(wb_valid, "R8 wb strobe", 64'(wb_valid), 64'h1);
            chk(wb_sel == v.rt, "R8 wb dest", 64'(wb_sel), 64'(v.rt));
            chk(wb_data == exp_wb, "R8 wb data", wb_data, exp_wb);
            @(posedge clk);
            @(negedge clk);
            chk(!wb_valid && instr_ready, "R8 single strobe", 64'({wb_valid, instr_ready}), 64'h1);
        end else begin
            chk(undef_flag == (v.kind == K_UND), "R1 R2 undef flag", 64'(undef_flag), 64'(v.kind == K_UND));
            chk(align_fault == (v.kind == K_ALN), "R6 align flag", 64'(align_fault), 64'(v.kind == K_ALN));
            chk(!mem_req_valid && !wb_valid, "R2 R6 no access", 64'({mem_req_valid, wb_valid}), 64'h0);
            @(posedge clk);
            @(negedge clk);
            chk(!undef_flag && !align_fault && !mem_req_valid && !wb_valid && instr_ready,
                "R2 R6 flag one cycle, idle", 64'({undef_flag, align_fault, mem_req_valid, wb_valid}), 64'h0);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) gpr[i] = '0;
        gpr[1] = 64'h0000_0000_0000_1000;
        gpr[2] = 64'h0000_0000_FFFF_FFFE;
        gpr[3] = 64'hFFFF_FFFF_FFFF_FFF0;
        gpr[4] = 64'h0000_0000_0000_0010;
        gpr[5] = 64'h1234_5678_0000_0004;

        // R10: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(instr_ready, "R10 ready in reset", 64'(instr_ready), 64'h1);
        chk(!mem_req_valid && !wb_valid && !undef_flag && !align_fault, "R10 outputs quiet",
            64'({mem_req_valid, wb_valid, undef_flag, align_fault}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(instr_ready && !mem_req_valid, "R10 idle after reset", 64'({instr_ready, mem_req_valid}), 64'h2);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R7 R9: stall on ready, busy instruction dropped, stall on response.
        @(negedge clk);
        sp_value    = 64'h8000;
        instr_word  = enc(VECS[1]);
        instr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        instr_valid   = 1'b0;
        mem_req_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        instr_word  = enc(VECS[0]);
        instr_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            chk(mem_req_valid && mem_req_addr == 64'h1020, "R7 held request",
                mem_req_addr, 64'h1020);
            chk(!instr_ready, "R9 not ready while busy", 64'(instr_ready), 64'h0);
            @(posedge clk);
            @(negedge clk);
        end
        chk(mem_req_valid, "R7 still held", 64'(mem_req_valid), 64'h1);
        instr_valid   = 1'b0;
        mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!mem_req_valid && !wb_valid, "R7 request dropped after ready",
            64'({mem_req_valid, wb_valid}), 64'h0);
        @(posedge clk);
        @(negedge clk);
        chk(!wb_valid, "R8 waits for response", 64'(wb_valid), 64'h0);
        mem_rsp_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(wb_valid && wb_data == {48'h0, 16'h1020 ^ 16'hC3A5} && wb_sel == 5'd8,
            "R8 wb after response", wb_data, {48'h0, 16'h1020 ^ 16'hC3A5});
        @(posedge clk);
        @(negedge clk);
        chk(instr_ready && !wb_valid, "R9 idle after wb", 64'({instr_ready, wb_valid}), 64'h2);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(!mem_req_valid && !wb_valid && instr_ready, "R9 busy instruction dropped",
            64'({mem_req_valid, wb_valid}), 64'h0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule